// File: doc/BRIEF.md
# Eight-bit logic and compare ALU with registered flags

This block is the bitwise, compare and step unit of an accumulator-based processor datapath. Each cycle in which the strobe is high, it takes the accumulator byte, a second byte and an operation code. The second byte is already chosen upstream from a register, an immediate or memory. The block also takes the flag byte the core currently holds. One clock later it presents the new data byte and the new flag byte from its own registers.

Six operations are supported: AND, OR, XOR, compare, increment and decrement. Each operation has its own flag rule. Compare only produces flags and hands the accumulator back unchanged. Increment and decrement act on the second byte, so the core can apply them to any register. They carry the incoming carry bit across untouched. The remaining two operation codes pass the accumulator and the incoming flags straight through.

Top module: `byte_logic_alu`

## Requirements
- R1: Op code 0 (AND) yields acc & operand, and sets Z when that result is zero. It forces H to 1 and clears N and C.
- R2: Op code 1 (OR) and op code 2 (XOR) yield acc | operand and acc ^ operand respectively. Both set Z from the result and clear N, H and C.
- R3: Op code 3 (compare) returns the accumulator unchanged as the result. It sets N to 1, sets Z when acc equals the operand, and sets C when acc is below the operand as an unsigned value.
- R4: Compare sets H exactly when the low nibble of acc is below the low nibble of the operand.
- R5: Op code 4 (increment) yields operand + 1, wrapping so that 0xFF gives 0x00 with Z set. It clears N and sets H exactly when the operand's low nibble is 0xF.
- R6: Op code 5 (decrement) yields operand - 1, wrapping so that 0x00 gives 0xFF. It sets N, sets Z from the result, and sets H exactly when the operand's low nibble is 0x0.
- R7: Increment and decrement copy the incoming carry (flag input bit 4) to the output carry.
- R8: The flag byte holds Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, and its bits 3..0 always read as zero.
- R9: The outputs update on the clock edge after a cycle with the strobe high, and the output valid is high for exactly those cycles. Without the strobe, the result and flags hold their values.
- R10: Op codes 6 and 7 return the accumulator as the result. They return the incoming flag byte with bits 3..0 cleared.
- R11: While reset is asserted, the result, flag byte and output valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vld_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| acc_i | input | W | Accumulator byte |
| opnd_i | input | W | Second operand byte |
| flags_i | input | W | Current flag byte |
| vld_o | output | 1 | Result valid, one cycle after the strobe |
| res_o | output | W | Registered result byte |
| flags_o | output | W | Registered flag byte |

## Verification
The bench builds the block at its default width of W = 8, which keeps the byte and nibble boundaries real. At that width, the wrap of 0xFF to 0x00 on increment and of 0x00 to 0xFF on decrement can be reached directly. So can the nibble edges 0xF and 0x0, and compares where the whole byte and the low nibble disagree. A long random stream covers all eight op codes, including the two pass-through codes. Gaps in the strobe, with changing inputs, show that the outputs hold.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_CMP  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

  localparam int HALF_W = 4;

endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   r_o,
  output logic           zero_o
);

  always_comb begin
    unique case (op_i)
      OP_OR:   r_o = a_i | b_i;
      OP_XOR:  r_o = a_i ^ b_i;
      default: r_o = a_i & b_i;
    endcase
  end

  assign zero_o = (r_o == '0);

endmodule

// File: rtl/alu_stepper.sv
module alu_stepper
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          dec_i,
  input  logic [W-1:0]  b_i,
  output logic [W-1:0]  r_o,
  output logic          zero_o,
  output logic          half_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [HALF_W-1:0] low_nib;

  assign low_nib = b_i[HALF_W-1:0];
  assign r_o     = dec_i ? (b_i - ONE) : (b_i + ONE);
  assign zero_o  = (r_o == '0);
  // borrow out of the low nibble on a step down, carry out of it on a step up
  assign half_o  = dec_i ? (low_nib == '0) : (&low_nib);

endmodule

// File: rtl/alu_compare.sv
module alu_compare
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o,
  output logic         lt_o,
  output logic         nib_lt_o
);

  assign eq_o     = (a_i == b_i);
  assign lt_o     = (a_i < b_i);
  assign nib_lt_o = (a_i[HALF_W-1:0] < b_i[HALF_W-1:0]);

endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_flags_t    f_i,
  output logic [W-1:0]  byte_o
);

  localparam int ZP = W - 1;
  localparam int NP = W - 2;
  localparam int HP = W - 3;
  localparam int CP = W - 4;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == ZP) begin : g_z
      assign byte_o[i] = f_i.z;
    end else if (i == NP) begin : g_n
      assign byte_o[i] = f_i.n;
    end else if (i == HP) begin : g_h
      assign byte_o[i] = f_i.h;
    end else if (i == CP) begin : g_c
      assign byte_o[i] = f_i.c;
    end else begin : g_zero
      assign byte_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/byte_logic_alu.sv
module byte_logic_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  acc_i,
  input  logic [W-1:0]  opnd_i,
  input  logic [W-1:0]  flags_i,
  output logic          vld_o,
  output logic [W-1:0]  res_o,
  output logic [W-1:0]  flags_o
);

  localparam int           CP      = W - 4;
  localparam logic [W-1:0] HI_MASK = {4'hF, {(W-4){1'b0}}};

  // reset synchronizer: assert at once, release on the clock
  logic rst_meta_n, rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_ok_n   <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_ok_n   <= rst_meta_n;
    end
  end

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [W-1:0] bw_r, st_r;
  logic         bw_z, st_z, st_h;
  logic         cm_eq, cm_lt, cm_nlt;

  alu_bitwise #(.W(W)) u_bitwise (
    .op_i   (op),
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .r_o    (bw_r),
    .zero_o (bw_z)
  );

  alu_stepper #(.W(W)) u_stepper (
    .dec_i  (op == OP_DEC),
    .b_i    (opnd_i),
    .r_o    (st_r),
    .zero_o (st_z),
    .half_o (st_h)
  );

  alu_compare #(.W(W)) u_compare (
    .a_i      (acc_i),
    .b_i      (opnd_i),
    .eq_o     (cm_eq),
    .lt_o     (cm_lt),
    .nib_lt_o (cm_nlt)
  );

  alu_flags_t   fl_nxt;
  logic [W-1:0] fl_packed;
  logic [W-1:0] res_nxt, flg_nxt;

  alu_flag_pack #(.W(W)) u_pack (
    .f_i    (fl_nxt),
    .byte_o (fl_packed)
  );

  // next-state: result and flag set per operation
  always_comb begin
    res_nxt = acc_i;
    fl_nxt  = '0;
    unique case (op)
      OP_AND: begin
        res_nxt = bw_r;
        fl_nxt  = '{z: bw_z, n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_OR, OP_XOR: begin
        res_nxt = bw_r;
        fl_nxt  = '{z: bw_z, n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_CMP: begin
        res_nxt = acc_i;
        fl_nxt  = '{z: cm_eq, n: 1'b1, h: cm_nlt, c: cm_lt};
      end
      OP_INC, OP_DEC: begin
        res_nxt = st_r;
        fl_nxt  = '{z: st_z, n: (op == OP_DEC), h: st_h, c: flags_i[CP]};
      end
      default: begin
        res_nxt = acc_i;
        fl_nxt  = '0;
      end
    endcase
  end

  always_comb begin
    if (op == OP_RSV6 || op == OP_RSV7) flg_nxt = flags_i & HI_MASK;
    else                                flg_nxt = fl_packed;
  end

  // registers with explicit enable
  logic         vld_q;
  logic [W-1:0] res_q, flg_q;

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        res_q <= res_nxt;
        flg_q <= flg_nxt;
      end
    end
  end

  assign vld_o   = vld_q;
  assign res_o   = res_q;
  assign flags_o = flg_q;

endmodule

// File: rtl/byte_logic_alu_chk.sv
module byte_logic_alu_chk
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_ok_n,
  input logic          vld_i,
  input logic [2:0]    op_i,
  input logic [W-1:0]  acc_i,
  input logic [W-1:0]  flags_i,
  input logic          vld_o,
  input logic [W-1:0]  res_o,
  input logic [W-1:0]  flags_o
);

  localparam int ZP = W - 1;
  localparam int NP = W - 2;
  localparam int HP = W - 3;
  localparam int CP = W - 4;

  assert_low_nibble_zero_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    flags_o[CP-1:0] == '0);

  assert_and_flags_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (vld_i && op_i == OP_AND) |=> (flags_o[HP] && !flags_o[NP] && !flags_o[CP]));

  assert_cmp_keeps_acc_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (vld_i && op_i == OP_CMP) |=> (res_o == $past(acc_i) && flags_o[NP]));

  assert_step_keeps_carry_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (vld_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[CP] == $past(flags_i[CP])));

  assert_zero_from_result_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (vld_i && op_i != OP_CMP && op_i != OP_RSV6 && op_i != OP_RSV7)
      |=> (flags_o[ZP] == (res_o == '0)));

  assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !vld_i |=> ($stable(res_o) && $stable(flags_o) && !vld_o));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    vld_i |=> vld_o);

  assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (vld_i && (op_i == OP_RSV6 || op_i == OP_RSV7))
      |=> (res_o == $past(acc_i) && flags_o[ZP:CP] == $past(flags_i[ZP:CP])));

endmodule

bind byte_logic_alu byte_logic_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_ok_n),
  .vld_i    (vld_i),
  .op_i     (op_i),
  .acc_i    (acc_i),
  .flags_i  (flags_i),
  .vld_o    (vld_o),
  .res_o    (res_o),
  .flags_o  (flags_o)
);

// File: tb/byte_logic_alu_tb.sv
module byte_logic_alu_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         vld_i;
  logic [2:0]   op_i;
  logic [W-1:0] acc_i, opnd_i, flags_i;
  logic         vld_o;
  logic [W-1:0] res_o, flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [2:0]  q_op  [$];
  logic [15:0] q_exp [$];

  always #4 clk = ~clk;  // 125 MHz

  byte_logic_alu #(.W(W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (vld_i),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .vld_o   (vld_o),
    .res_o   (res_o),
    .flags_o (flags_o)
  );

  // expected {result, flags} from the requirements; flags Z7 N6 H5 C4 (R8)
  function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] fin);
    logic [7:0] r;
    logic z, n, h, c;
    r = a; z = 0; n = 0; h = 0; c = 0;
    case (op)
      3'd0: begin r = a & b; z = (r == 0); h = 1; end                    // R1
      3'd1: begin r = a | b; z = (r == 0); end                           // R2
      3'd2: begin r = a ^ b; z = (r == 0); end                           // R2
      3'd3: begin r = a; z = (a == b); n = 1; c = (a < b);
                  h = (a[3:0] < b[3:0]); end                             // R3 R4
      3'd4: begin r = b + 8'd1; z = (r == 0); h = (b[3:0] == 4'hF);
                  c = fin[4]; end                                        // R5 R7
      3'd5: begin r = b - 8'd1; z = (r == 0); n = 1; h = (b[3:0] == 4'h0);
                  c = fin[4]; end                                        // R6 R7
      default: return {a, fin[7:4], 4'h0};                               // R10
    endcase
    return {r, z, n, h, c, 4'h0};
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1, 3'd2: return "R2";
      3'd3: return "R3/R4";
      3'd4: return "R5/R7";
      3'd5: return "R6/R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one strobe per call, expected item pushed to the scoreboard
  task automatic send(input logic [2:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] f);
    @(negedge clk);
    vld_i = 1'b1; op_i = op; acc_i = a; opnd_i = b; flags_i = f;
    q_op.push_back(op);
    q_exp.push_back(model(op, a, b, f));
  endtask

  task automatic idle();
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  // monitor: pops and compares when a result is presented
  always @(negedge clk) begin
    if (!done && rst_n && vld_o) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R9", 1, 0);
      end else begin
        logic [2:0]  op;
        logic [15:0] e;
        op = q_op.pop_front();
        e  = q_exp.pop_front();
        check({res_o, flags_o} == e, tag(op), {res_o, flags_o}, e);
        check(flags_o[3:0] == 4'h0, "R8", flags_o, {flags_o[7:4], 4'h0});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] hr, hf;
    rst_n = 1'b0; vld_i = 1'b0; op_i = '0; acc_i = '0; opnd_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    check(res_o == 0 && flags_o == 0 && vld_o == 0, "R11", {vld_o, res_o, flags_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 AND: zero and nonzero results
    send(3'd0, 8'hF0, 8'h0F, 8'h00);
    send(3'd0, 8'h3C, 8'h2A, 8'hF0);
    // R2 OR / XOR
    send(3'd1, 8'h00, 8'h00, 8'hF0);
    send(3'd1, 8'h81, 8'h42, 8'h00);
    send(3'd2, 8'h5A, 8'h5A, 8'h10);
    send(3'd2, 8'h5A, 8'hA5, 8'h00);
    // R3 R4 compare: equal, below, above, nibble disagreement
    send(3'd3, 8'h44, 8'h44, 8'h00);
    send(3'd3, 8'h10, 8'h2F, 8'h00);
    send(3'd3, 8'h2F, 8'h10, 8'h00);
    send(3'd3, 8'h21, 8'h12, 8'h00);
    // R5 increment: wrap and nibble edge, carry in 1 and 0 (R7)
    send(3'd4, 8'h00, 8'hFF, 8'h10);
    send(3'd4, 8'h00, 8'h0F, 8'h00);
    send(3'd4, 8'h00, 8'h41, 8'h10);
    // R6 decrement: wrap, to zero, nibble edge
    send(3'd5, 8'h00, 8'h00, 8'h00);
    send(3'd5, 8'h00, 8'h01, 8'h10);
    send(3'd5, 8'h00, 8'h30, 8'h00);
    // R10 pass-through codes with junk low nibble
    send(3'd6, 8'h9C, 8'h11, 8'hAF);
    send(3'd7, 8'h03, 8'h22, 8'h5B);
    idle();
    @(negedge clk);

    // R9 hold: inputs change with no strobe
    hr = res_o; hf = flags_o;
    vld_i = 1'b0; op_i = 3'd2; acc_i = 8'hFF; opnd_i = 8'h0F; flags_i = 8'hF0;
    repeat (3) @(negedge clk);
    check(res_o == hr && flags_o == hf && !vld_o, "R9", {res_o, flags_o}, {hr, hf});

    // random stream over all codes, with occasional gaps
    for (int i = 0; i < 400; i++) begin
      send(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 8'($urandom));
      if ((i % 17) == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R9", q_exp.size(), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule